// File: doc/BRIEF.md
# Serial EEPROM Slave Engine

This block is the device side of a byte-addressed serial EEPROM that sits on an SPI bus in mode 0. It has a chip select, a serial clock, a serial input and a serial output. All four bus lines are sampled into the system clock domain. Edges of the serial clock are found there, so the serial clock must run well below the system clock; the bench uses at least six system clocks per SCK phase. The block recognises four instructions. The first sets a write-enable latch. The second returns a status byte. The third streams bytes out of the storage array from a start address. The fourth loads up to one page of bytes and commits them when chip select rises.

A committed page starts an internal write cycle that lasts a fixed number of system clocks and shows as a busy flag. A two-bit protection level input fences off an upper region of the array, and bytes that fall inside it are dropped at commit. SPI has no back-pressure: the master owns the clock, and the block accepts or presents one bit per SCK period with no stall. For that reason the bus is not wrapped in a valid/ready handshake, and the protection level stays a plain control input.

Top module: `ee_spi_slave`

## Requirements
- R1: After reset the write-enable latch is clear, the device is not busy, every array byte reads 0x00, and `spi_miso_oe` is low.
- R2: Opcode 0x06 sets the write-enable latch. Opcode 0x05 returns a status byte whose bit 0 is busy, bit 1 is the write-enable latch and bits 7:2 are zero. The status byte repeats, freshly sampled, for every further byte clocked while chip select stays low.
- R3: Opcode 0x03 is followed by a 16-bit address sent MSB first, of which the low ADDR_W bits are used. Data then leaves MSB first, one byte per eight clocks. The address advances after each byte and wraps from DEPTH-1 to 0.
- R4: Opcode 0x02 with the write-enable latch clear is ignored. No byte changes, no write cycle starts and the latch stays clear.
- R5: During a page write only the low five address bits advance after each data byte, and the upper bits stay fixed. A 33rd or later byte wraps inside the 32-byte page and replaces the byte loaded there earlier.
- R6: A page write commits only if chip select rises while SCK is low, after the last bit of a whole data byte. A rise in the middle of a byte, or while SCK is still high after the final bit, discards the page, starts no write cycle and keeps the latch set.
- R7: A commit makes the device busy for WR_CYCLES system clocks. When the busy period ends, the write-enable latch clears on its own.
- R8: While busy, only opcode 0x05 is honoured. A read leaves `spi_miso_oe` low, and a 0x06 opcode leaves the latch unchanged.
- R9: Protection level 0 protects nothing, level 1 protects the top quarter of the array, level 2 the top half and level 3 all of it. Bytes aimed at protected addresses stay unchanged, but the write cycle still runs and clears the latch.
- R10: Any other opcode makes the device ignore the rest of the transaction until chip select rises, and `spi_miso_oe` stays low.
- R11: Input bits are taken on rising SCK and output bits change after falling SCK. `spi_miso_oe` is high only while read or status data is being shifted out, and `spi_miso` is 0 whenever `spi_miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_lvl | input | 2 | Block protection level, 0 to 3 |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data into the device |
| spi_miso | output | 1 | Serial data out of the device, 0 when not driven |
| spi_miso_oe | output | 1 | High while the device drives `spi_miso` |

## Verification
The hardest situations to reach are a chip-select rise that lands on the wrong side of the last SCK edge, and an instruction that arrives inside the short busy window. The bench reaches the first by driving the data bits by hand: it raises chip select either after four bits of a byte or while SCK is still high after the final bit. It then reads the status and the page back to show that nothing changed. It reaches the second by lengthening the write cycle and issuing a status read, a read and a write-enable back to back straight after a commit. A full sweep writes every page and reads the whole array plus a wrap in one stream, and compares each byte with a model computed in the bench.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_OP, ST_ADDR, ST_RDATA, ST_WDATA, ST_STAT, ST_IGNORE
  } ee_state_e;

  // top2 = the two most significant address bits of the page
  function automatic logic prot_hit(input logic [1:0] lvl, input logic [1:0] top2);
    case (lvl)
      2'd0:    return 1'b0;
      2'd1:    return top2 == 2'b11;
      2'd2:    return top2[1];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ee_wr_timer.sv
module ee_wr_timer #(
  parameter int CYCLES = 1000,
  localparam int TW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [TW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
      busy <= 1'b0;
    end else if (start) begin
      left <= TW'(CYCLES);
      busy <= 1'b1;
    end else if (busy) begin
      left <= left - 1'b1;
      if (left == TW'(1)) busy <= 1'b0;
    end
  end

  assign done = busy && (left == TW'(1));
endmodule

// File: rtl/ee_array.sv
module ee_array #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 5,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int PAGE = 1 << PAGE_W,
  localparam int BASE_W = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata,
  input  logic              wr_en,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [PAGE*8-1:0] wr_data,
  input  logic [PAGE-1:0]   wr_mask
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (wr_en) begin
      for (int j = 0; j < PAGE; j++)
        if (wr_mask[j]) mem[{wr_base, PAGE_W'(j)}] <= wr_data[j*8 +: 8];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ee_spi_slave.sv
module ee_spi_slave #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 5,
  parameter int WR_CYCLES = 1000,
  parameter int SYNC_STAGES = 2,
  localparam int PAGE = 1 << PAGE_W,
  localparam int BASE_W = ADDR_W - PAGE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] prot_lvl,
  input  logic       spi_cs_n,
  input  logic       spi_sck,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       spi_miso_oe
);
  import ee_pkg::*;

  logic cs_s, sck_s, mosi_s, cs_q, sck_q;
  spi_edge_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sck, spi_mosi}), .q({cs_s, sck_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
    end
  end

  logic sck_rise, sck_fall, cs_rise;
  assign sck_rise = sck_s & ~sck_q & ~cs_s;
  assign sck_fall = ~sck_s & sck_q & ~cs_s;
  assign cs_rise  = cs_s & ~cs_q;

  ee_state_e        state;
  logic [3:0]        cnt;
  logic [7:0]        sh_in, sh_out;
  logic [15:0]       addr_sh;
  logic              is_wr, wel, got_byte, done_low, oe_q, miso_q;
  logic [ADDR_W-1:0] rd_addr;
  logic [BASE_W-1:0] page_base;
  logic [PAGE_W-1:0] page_off;
  logic [7:0]        pbuf [PAGE];
  logic [PAGE-1:0]   pvalid;
  logic              busy, wr_done, commit;
  logic [ADDR_W-1:0] arr_raddr, addr_full;
  logic [7:0]        arr_rdata, status, op_in, byte_in;

  assign status    = {6'b0, wel, busy};
  assign op_in     = {sh_in[6:0], mosi_s};
  assign byte_in   = op_in;
  assign addr_full = {addr_sh[ADDR_W-2:0], mosi_s};
  assign arr_raddr = (state == ST_ADDR) ? addr_full : rd_addr + 1'b1;
  assign commit    = cs_rise && (state == ST_WDATA) && done_low;

  // page buffer flattening and protection mask
  logic [PAGE*8-1:0] pdata_flat;
  logic              page_prot;
  for (genvar i = 0; i < PAGE; i++) begin : g_pack
    assign pdata_flat[i*8 +: 8] = pbuf[i];
  end
  assign page_prot = prot_hit(prot_lvl, page_base[BASE_W-1 -: 2]);

  ee_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .raddr(arr_raddr), .rdata(arr_rdata),
    .wr_en(commit), .wr_base(page_base), .wr_data(pdata_flat),
    .wr_mask(pvalid & {PAGE{~page_prot}})
  );

  ee_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy), .done(wr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OP;
      cnt       <= '0;
      sh_in     <= '0;
      sh_out    <= '0;
      addr_sh   <= '0;
      is_wr     <= 1'b0;
      wel       <= 1'b0;
      got_byte  <= 1'b0;
      done_low  <= 1'b0;
      oe_q      <= 1'b0;
      miso_q    <= 1'b0;
      rd_addr   <= '0;
      page_base <= '0;
      page_off  <= '0;
      pvalid    <= '0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= 8'h00;
    end else begin
      if (cs_s) begin
        state    <= ST_OP;
        cnt      <= '0;
        got_byte <= 1'b0;
        done_low <= 1'b0;
        oe_q     <= 1'b0;
        miso_q   <= 1'b0;
      end else if (sck_rise) begin
        cnt      <= cnt + 1'b1;
        done_low <= 1'b0;
        unique case (state)
          ST_OP: begin
            sh_in <= op_in;
            if (cnt == 4'd7) begin
              cnt <= '0;
              case (op_in)
                OP_WREN: begin
                  if (!busy) wel <= 1'b1;
                  state <= ST_IGNORE;
                end
                OP_RDSR: begin
                  sh_out <= status;
                  state  <= ST_STAT;
                end
                OP_READ: begin
                  is_wr <= 1'b0;
                  state <= busy ? ST_IGNORE : ST_ADDR;
                end
                OP_WRITE: begin
                  is_wr <= 1'b1;
                  state <= (busy || !wel) ? ST_IGNORE : ST_ADDR;
                end
                default: state <= ST_IGNORE;
              endcase
            end
          end
          ST_ADDR: begin
            addr_sh <= {addr_sh[14:0], mosi_s};
            if (cnt == 4'd15) begin
              cnt <= '0;
              if (is_wr) begin
                page_base <= addr_full[ADDR_W-1:PAGE_W];
                page_off  <= addr_full[PAGE_W-1:0];
                pvalid    <= '0;
                state     <= ST_WDATA;
              end else begin
                rd_addr <= addr_full;
                sh_out  <= arr_rdata;
                state   <= ST_RDATA;
              end
            end
          end
          ST_RDATA: begin
            if (cnt == 4'd7) begin
              cnt     <= '0;
              rd_addr <= rd_addr + 1'b1;
              sh_out  <= arr_rdata;
            end
          end
          ST_STAT: begin
            if (cnt == 4'd7) begin
              cnt    <= '0;
              sh_out <= status;
            end
          end
          ST_WDATA: begin
            sh_in <= byte_in;
            if (cnt == 4'd7) begin
              cnt              <= '0;
              pbuf[page_off]   <= byte_in;
              pvalid[page_off] <= 1'b1;
              page_off         <= page_off + 1'b1;
              got_byte         <= 1'b1;
            end
          end
          default: cnt <= '0;
        endcase
      end else if (sck_fall) begin
        if (state == ST_RDATA || state == ST_STAT) begin
          miso_q <= sh_out[7];
          sh_out <= {sh_out[6:0], 1'b0};
          oe_q   <= 1'b1;
        end
        if (state == ST_WDATA && cnt == 4'd0 && got_byte) done_low <= 1'b1;
      end
      if (wr_done) wel <= 1'b0;
    end
  end

  assign spi_miso_oe = oe_q;
  assign spi_miso    = oe_q & miso_q;
endmodule

// File: rtl/ee_spi_slave_chk.sv
module ee_spi_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic spi_miso_oe,
  input logic busy,
  input logic wel,
  input logic commit
);
  AST_COMMIT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (wel && !busy)); // R4
  AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy); // R7
  AST_WEL_CLEAR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel); // R7
  AST_WEL_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wel) |=> !wel); // R8
  AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe); // R11
endmodule

bind ee_spi_slave ee_spi_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
  .busy(busy), .wel(wel), .commit(commit)
);

// File: tb/ee_spi_slave_tb.sv
module ee_spi_slave_tb;
  localparam int H = 6;
  localparam int WRC = 1500;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] prot_lvl = 2'd0;
  logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  int n_chk = 0, n_fail = 0;
  bit oe_seen = 1'b0, done = 1'b0;
  logic [7:0] model [256];

  always #4 clk = ~clk;

  ee_spi_slave #(.WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .prot_lvl(prot_lvl),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
  );

  always @(negedge clk) begin
    if (spi_miso_oe) oe_seen = 1'b1;
    if (!spi_miso_oe && spi_miso !== 1'b0 && rst_n) begin
      n_chk++; n_fail++;
      $display("FAIL R11: miso=%b expected 0 while undriven", spi_miso);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo();
    oe_seen = 1'b0; spi_cs_n = 1'b0; wait_n(H);
  endtask

  task automatic cs_hi();
    wait_n(H); spi_cs_n = 1'b1; wait_n(2*H);
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - nb; b--) begin
      spi_mosi = tx[b];
      wait_n(H);
      rx[b] = spi_miso;
      spi_sck = 1'b1;
      wait_n(H);
      spi_sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xfer_bits(tx, 8, rx);
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] d;
    cs_lo(); xfer(8'h05, d); xfer(8'h00, st); cs_hi();
  endtask

  task automatic wren();
    logic [7:0] d;
    cs_lo(); xfer(8'h06, d); cs_hi();
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    for (int k = 0; k < 60; k++) begin
      rdsr(st);
      if (!st[0]) break;
    end
    check("R7 idle after cycle", {24'h0, st}, 32'h0);
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'(seed + k * 13);
  endfunction

  function automatic bit prot(input logic [7:0] a);
    case (prot_lvl)
      2'd0: return 1'b0;
      2'd1: return a >= 8'hC0;
      2'd2: return a >= 8'h80;
      default: return 1'b1;
    endcase
  endfunction

  // full page write; commits and updates the model
  task automatic page_write(input logic [7:0] a, input int n, input int seed);
    logic [7:0] d;
    cs_lo(); xfer(8'h02, d); xfer(8'h00, d); xfer(a, d);
    for (int k = 0; k < n; k++) xfer(pat(seed, k), d);
    cs_hi();
    for (int k = 0; k < n; k++) begin
      logic [7:0] t;
      t = {a[7:5], 5'(a[4:0] + k)};
      if (!prot(t)) model[t] = pat(seed, k);
    end
  endtask

  task automatic read_chk(input string req, input logic [7:0] a, input int n);
    logic [7:0] d;
    cs_lo(); xfer(8'h03, d); xfer(8'h00, d); xfer(a, d);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, d);
      check(req, {24'h0, d}, {24'h0, model[8'(a + k)]});
    end
    cs_hi();
  endtask

  initial begin
    logic [7:0] st, d;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    wait_n(5); rst_n = 1'b1; wait_n(5);

    // R1 reset state
    check("R1 oe low", {31'h0, spi_miso_oe}, 32'h0);
    rdsr(st); check("R1 status", {24'h0, st}, 32'h0);
    read_chk("R1 array zero", 8'h00, 4);

    // R2 status repeats
    wren();
    cs_lo(); xfer(8'h05, d); xfer(8'h00, st); xfer(8'h00, d); cs_hi();
    check("R2 wel set", {24'h0, st}, 32'h2);
    check("R2 status repeat", {24'h0, d}, 32'h2);
    check("R11 oe during status", {31'h0, oe_seen}, 32'h1);

    // R4 write without latch
    wait_n(2); rdsr(st);
    // clear latch with a committed cycle first
    page_write(8'h10, 4, 1); wait_idle();
    read_chk("R7 page data", 8'h10, 4);
    cs_lo(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h10, d); xfer(8'hAA, d); cs_hi();
    rdsr(st); check("R4 no cycle no latch", {24'h0, st}, 32'h0);
    read_chk("R4 data unchanged", 8'h10, 1);

    // R5 page wrap: 34 bytes from offset 30 of page 1
    wren(); page_write(8'h3E, 34, 40); wait_idle();
    read_chk("R5 page wrap", 8'h20, 32);

    // R3 wrap across array top
    wren(); page_write(8'hFE, 2, 90); wait_idle();
    read_chk("R3 read wrap", 8'hFE, 4);

    // R6 abort mid-byte
    wren();
    cs_lo(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h50, d); xfer(8'h11, d);
    xfer_bits(8'h22, 4, d); cs_hi();
    rdsr(st); check("R6 mid-byte abort", {24'h0, st}, 32'h2);
    read_chk("R6 mid-byte data", 8'h50, 2);

    // R6 abort with SCK still high after D0
    cs_lo(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h50, d); xfer(8'h33, d);
    xfer_bits(8'h44, 7, d);
    spi_mosi = 1'b0; wait_n(H); spi_sck = 1'b1; wait_n(H);
    spi_cs_n = 1'b1; wait_n(2*H); spi_sck = 1'b0; wait_n(2*H);
    rdsr(st); check("R6 sck-high abort", {24'h0, st}, 32'h2);
    read_chk("R6 sck-high data", 8'h50, 2);

    // R7/R8 behaviour while busy
    page_write(8'h60, 3, 7);
    rdsr(st); check("R7 busy and wel", {24'h0, st}, 32'h3);
    cs_lo(); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h60, d); xfer(8'h00, d); cs_hi();
    check("R8 read ignored while busy", {31'h0, oe_seen}, 32'h0);
    wren();
    wait_idle();
    read_chk("R7 data after cycle", 8'h60, 3);

    // R9 protection levels
    prot_lvl = 2'd2;
    wren(); page_write(8'h90, 2, 3); wait_idle();
    read_chk("R9 lvl2 protected", 8'h90, 2);
    wren(); page_write(8'h40, 2, 5); wait_idle();
    read_chk("R9 lvl2 open", 8'h40, 2);
    prot_lvl = 2'd1;
    wren(); page_write(8'hE0, 2, 9); wait_idle();
    read_chk("R9 lvl1 protected", 8'hE0, 2);
    wren(); page_write(8'hA0, 2, 11); wait_idle();
    read_chk("R9 lvl1 open", 8'hA0, 2);
    prot_lvl = 2'd3;
    wren(); page_write(8'h00, 2, 15); wait_idle();
    read_chk("R9 lvl3 protected", 8'h00, 2);
    prot_lvl = 2'd0;

    // R10 unknown opcode
    cs_lo(); xfer(8'h0B, d); xfer(8'h00, d); xfer(8'h00, d); xfer(8'h00, d); cs_hi();
    check("R10 unknown opcode quiet", {31'h0, oe_seen}, 32'h0);
    rdsr(st); check("R10 status untouched", {24'h0, st}, 32'h0);

    // R3/R5 exhaustive sweep over every page, read back in one stream
    for (int p = 0; p < 8; p++) begin
      wren(); page_write(8'(p * 32), 32, p * 5 + 1); wait_idle();
    end
    read_chk("R3 full sweep", 8'h00, 258);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule